// File: doc/BRIEF.md
# Step Decoder with Gate Bus Routing

This block turns a 4-bit step position from a sequencer into a one-hot set of step enables, a matching set of step indicator drives, and three gate bus lines. It is built from two 3-to-8 decoders, one per half of the step range.

In single-row mode the position's top bit picks which half decoder is enabled. Exactly one of the sixteen steps is then active. In paired mode both half decoders are enabled and decode the low three bits together, so step k and step k+8 are active at once.

Each step carries a 2-bit route code that sends it onto one of three gate buses, or onto none. A mask input blanks all three buses, for example while the sequencer moves between positions. The indicator outputs are not masked. All outputs are registered.

Top module: `step_gate_decoder`

## Requirements
- R1: All outputs are registered: each output reflects the inputs sampled at the previous rising clock edge. A synchronous active-high reset clears `step_en`, `led` and `gate_bus` to zero.
- R2: With `dual_mode`=0, `step_en` has exactly one bit set, at index `pos` (bit 0 is the first step, bit 15 the last).
- R3: With `dual_mode`=1, `step_en` has exactly bits `pos[2:0]` and `pos[2:0]+8` set, and `pos[3]` has no effect.
- R4: Step i's route code is `bus_sel[2i+1:2i]`. Codes 0, 1 and 2 select `gate_bus` bit 0, 1 and 2. A `gate_bus` bit is 1 when at least one active step carries its code and the mask is low.
- R5: A step whose route code is 3 drives no gate bus.
- R6: While `mask` is 1, `gate_bus` is all zero on the next cycle.
- R7: `led` equals `step_en` at all times, whatever the value of `mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pos | input | 4 | Latched step position |
| dual_mode | input | 1 | 0: one row of 16 steps, 1: two parallel rows of 8 |
| bus_sel | input | 32 | Route code per step, 2 bits each, step i at [2i+1:2i] |
| mask | input | 1 | Blanks the gate buses |
| step_en | output | 16 | One-hot (or paired) step enables |
| led | output | 16 | Step indicator drives |
| gate_bus | output | 3 | Gate bus lines |

## Verification
The hardest situation to reach is in paired mode: the two simultaneously active steps must carry route codes that either collide on one bus, split across two buses, or include code 3. A blanked bus must also be told apart from one that no step selects. The stimulus reaches these cases with directed vectors that set the paired steps' codes explicitly, with mask both high and low. Random vectors draw every route code, including 3, in both modes.

// File: rtl/step_dec_pkg.sv
package step_dec_pkg;
  // Default geometry of the decoder
  localparam int unsigned POS_W_DEF   = 4;
  localparam int unsigned BUSES_DEF   = 3;
  localparam int unsigned SEL_W_DEF   = 2;

  // Route code values; anything at or above the bus count routes nowhere
  typedef enum logic [1:0] {
    ROUTE_BUS0 = 2'd0,
    ROUTE_BUS1 = 2'd1,
    ROUTE_BUS2 = 2'd2,
    ROUTE_OFF  = 2'd3
  } route_code_e;
endpackage

// File: rtl/step_half_decoder.sv
module step_half_decoder #(
  parameter int unsigned IDX_W = 3,
  localparam int unsigned OUTS = 2 ** IDX_W
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [OUTS-1:0]  onehot
);
  always_comb begin
    onehot = '0;
    if (en) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/step_bus_router.sv
module step_bus_router #(
  parameter int unsigned STEPS = 16,
  parameter int unsigned BUSES = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic [STEPS-1:0]       active,
  input  logic [STEPS*SEL_W-1:0] sel,
  output logic [BUSES-1:0]       bus
);
  for (genvar b = 0; b < BUSES; b++) begin : g_bus
    always_comb begin
      bus[b] = 1'b0;
      for (int i = 0; i < STEPS; i++) begin
        if (active[i] && (sel[i*SEL_W +: SEL_W] == SEL_W'(b))) bus[b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/step_gate_decoder.sv
module step_gate_decoder
  import step_dec_pkg::*;
#(
  parameter int unsigned POS_W = POS_W_DEF,
  parameter int unsigned BUSES = BUSES_DEF,
  parameter int unsigned SEL_W = SEL_W_DEF,
  localparam int unsigned STEPS = 2 ** POS_W,
  localparam int unsigned HALF  = STEPS / 2,
  localparam int unsigned IDX_W = POS_W - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [POS_W-1:0]       pos,
  input  logic                   dual_mode,
  input  logic [STEPS*SEL_W-1:0] bus_sel,
  input  logic                   mask,
  output logic [STEPS-1:0]       step_en,
  output logic [STEPS-1:0]       led,
  output logic [BUSES-1:0]       gate_bus
);
  logic [1:0]       half_en;
  logic [STEPS-1:0] active;
  logic [BUSES-1:0] routed;

  // Lower half on when top bit is clear, upper when set; both in paired mode
  assign half_en[0] = dual_mode | ~pos[POS_W-1];
  assign half_en[1] = dual_mode |  pos[POS_W-1];

  for (genvar h = 0; h < 2; h++) begin : g_half
    step_half_decoder #(.IDX_W(IDX_W)) u_dec (
      .en     (half_en[h]),
      .idx    (pos[IDX_W-1:0]),
      .onehot (active[h*HALF +: HALF])
    );
  end

  step_bus_router #(.STEPS(STEPS), .BUSES(BUSES), .SEL_W(SEL_W)) u_route (
    .active (active),
    .sel    (bus_sel),
    .bus    (routed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_en  <= '0;
      led      <= '0;
      gate_bus <= '0;
    end else begin
      step_en  <= active;
      led      <= active;
      gate_bus <= mask ? '0 : routed;
    end
  end
endmodule

// File: rtl/step_gate_decoder_chk.sv
module step_gate_decoder_chk #(
  parameter int unsigned POS_W = 4,
  parameter int unsigned BUSES = 3,
  parameter int unsigned SEL_W = 2,
  localparam int unsigned STEPS = 2 ** POS_W,
  localparam int unsigned HALF  = STEPS / 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [POS_W-1:0]       pos,
  input logic                   dual_mode,
  input logic [STEPS*SEL_W-1:0] bus_sel,
  input logic                   mask,
  input logic [STEPS-1:0]       step_en,
  input logic [STEPS-1:0]       led,
  input logic [BUSES-1:0]       gate_bus
);
  // R2: single-row mode gives exactly the addressed step
  p_single_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode)) |-> ($countones(step_en) == 1 && step_en[$past(pos)]));

  // R3: paired mode mirrors the two halves
  p_dual_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dual_mode)) |->
      (step_en[HALF-1:0] == step_en[STEPS-1:HALF] && $countones(step_en) == 2));

  // R4: one active step in single-row mode drives at most one bus
  p_bus_single_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode)) |-> $onehot0(gate_bus));

  // R5: unused code on the active step leaves all buses idle
  p_off_code_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode) && ($past(bus_sel[pos*SEL_W +: SEL_W]) == '1))
      |-> gate_bus == '0);

  // R6: mask blanks the buses
  p_mask_blank_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask)) |-> gate_bus == '0);

  // R7: indicators track enables
  p_led_track_r7: assert property (@(posedge clk) disable iff (rst)
    led == step_en);

  // R1: reset clears everything on the following edge
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (step_en == '0 && led == '0 && gate_bus == '0));
endmodule

bind step_gate_decoder step_gate_decoder_chk #(
  .POS_W(POS_W), .BUSES(BUSES), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .pos(pos), .dual_mode(dual_mode), .bus_sel(bus_sel),
  .mask(mask), .step_en(step_en), .led(led), .gate_bus(gate_bus)
);

// File: tb/test_step_gate_decoder.sv
`timescale 1ns/1ps
module test_step_gate_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pos = '0;
  logic        dual_mode = 1'b0;
  logic [31:0] bus_sel = '0;
  logic        mask = 1'b0;
  logic [15:0] step_en, led;
  logic [2:0]  gate_bus;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  step_gate_decoder i_step_gate_decoder (
    .clk(clk), .rst(rst), .pos(pos), .dual_mode(dual_mode), .bus_sel(bus_sel),
    .mask(mask), .step_en(step_en), .led(led), .gate_bus(gate_bus)
  );

  function automatic logic [15:0] exp_en(logic [3:0] p, logic d);
    logic [15:0] e = '0;
    if (d) begin
      e[{1'b0, p[2:0]}] = 1'b1;
      e[{1'b1, p[2:0]}] = 1'b1;
    end else e[p] = 1'b1;
    return e;
  endfunction

  function automatic logic [2:0] exp_bus(logic [15:0] e, logic [31:0] s, logic m);
    logic [2:0] b = '0;
    for (int i = 0; i < 16; i++)
      if (e[i] && s[2*i +: 2] != 2'd3) b[s[2*i +: 2]] = 1'b1;
    return m ? 3'b000 : b;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one vector, then sample one cycle later away from the edge
  task automatic apply(logic [3:0] p, logic d, logic [31:0] s, logic m, string req);
    logic [15:0] e;
    @(negedge clk);
    pos = p; dual_mode = d; bus_sel = s; mask = m;
    @(negedge clk);
    e = exp_en(p, d);
    check({req, " step_en"}, 32'(step_en), 32'(e));
    check("R7 led", 32'(led), 32'(e));
    check({req, " gate_bus"}, 32'(gate_bus), 32'(exp_bus(e, s, m)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset step_en", 32'(step_en), 32'h0);
    check("R1 reset led", 32'(led), 32'h0);
    check("R1 reset gate_bus", 32'(gate_bus), 32'h0);
    rst = 1'b0;

    // R2: every position in single-row mode, all steps on bus 1
    for (int p = 0; p < 16; p++) apply(4'(p), 1'b0, {16{2'b01}}, 1'b0, "R2");
    // R3: paired mode, both values of the top bit
    for (int p = 0; p < 16; p++) apply(4'(p), 1'b1, {16{2'b10}}, 1'b0, "R3");

    // R4: paired steps 3 and 11 on different buses, then the same bus
    apply(4'd3, 1'b1, (32'd0 << 6) | (32'd2 << 22), 1'b0, "R4");
    apply(4'd3, 1'b1, (32'd1 << 6) | (32'd1 << 22), 1'b0, "R4");
    // R5: code 3 on one paired step only, then on both
    apply(4'd5, 1'b1, (32'd3 << 10) | (32'd0 << 26), 1'b0, "R5");
    apply(4'd5, 1'b1, 32'hffff_ffff, 1'b0, "R5");
    apply(4'd12, 1'b0, 32'hffff_ffff, 1'b0, "R5");
    // R6/R7: mask blanks buses but leaves enables and indicators
    apply(4'd7, 1'b0, 32'h0, 1'b1, "R6");
    apply(4'd7, 1'b1, 32'h0000_8000 | 32'd2 << 14, 1'b1, "R6");
    apply(4'd7, 1'b0, 32'h0, 1'b0, "R6 release");

    // R1: registered output holds the previous sample one cycle
    @(negedge clk);
    pos = 4'd9; dual_mode = 1'b0; mask = 1'b0;
    @(posedge clk); #1;
    pos = 4'd2;
    @(negedge clk);
    check("R1 latency", 32'(step_en), 32'h0000_0200);

    // Random mix in both modes
    for (int n = 0; n < 400; n++)
      apply(4'($urandom()), 1'($urandom()), $urandom(), ($urandom() % 4) == 0, "R4 random");

    // R1: reset clears again after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 rereset", 32'({step_en, led}), 32'h0);
    check("R1 rereset bus", 32'(gate_bus), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule